// File: doc/BRIEF.md
# Switch Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from the DMA engines and port logic of an Ethernet switch. It holds each event in a sticky status bit and drives one level-sensitive interrupt line to the host. A status bit stays set until the host writes a 1 to that bit position.

A separate mask register lets the host silence any source: a 1 in the mask disables the matching source. Status bits keep recording events while they are masked. The host can also read a third view, the pending word, which is the status with the masked bits removed.

The host reaches all three views through a small word-addressed register port. Read data is registered. Each source has its own bit, so the number of bits grows with the number of switch ports. With the default six ports the status word is 17 bits wide.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register reads 0. The mask register reads all ones over its width (0x1FFFF with 6 ports). The interrupt output is low.
- R2: A 1 on an event input sets its status bit at the next clock edge, and the bit stays set. Bit layout:
  - bit 0: receive low done
  - bit 1: receive high done
  - bit 2: send low done
  - bit 3: send high done
  - bit 4: low descriptor full
  - bit 5: high descriptor full
  - bits 6 to 6+P-1: queue full for ports 0 to P-1
  - then, in order: CPU queue full, global queue full, receive descriptor error, send descriptor error, port status change (bits 12 to 16 with P=6)
- R3: A write to offset 0 clears exactly the status bits that are 1 in the written data. All other status bits keep their value.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit stays set.
- R5: A write to offset 1 loads the mask register from the low bits of the data. Written bits above the source width are dropped. A mask bit of 1 disables its source.
- R6: A masked source still sets its status bit, but the interrupt output stays low for it. Clearing the mask bit of a set status bit raises the interrupt at the edge that takes the write.
- R7: The interrupt output is high exactly while (status AND NOT mask) is nonzero. It is a level that stays high until the cause is cleared or masked, and it changes at the same edge as the registers.
- R8: Offset 2 reads the pending word (status AND NOT mask). Offset 3 reads zero. Bits above the source width always read zero. Writes to offsets 2 and 3 change nothing.
- R9: Read data appears on the clock edge after the address is presented. It shows the register values as they were before any write taken at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_xfer_i | input | 6 | Receive/send done and descriptor-full event pulses, status bits 0 to 5 |
| ev_qfull_i | input | NUM_PORTS | Per-port queue-full event pulses |
| ev_cpu_qfull_i | input | 1 | CPU port queue-full event pulse |
| ev_glb_qfull_i | input | 1 | Global queue-full event pulse |
| ev_rx_err_i | input | 1 | Receive descriptor error event pulse |
| ev_tx_err_i | input | 1 | Send descriptor error event pulse |
| ev_link_i | input | 1 | Port status change event pulse |
| reg_addr_i | input | 2 | Word offset: 0 status, 1 mask, 2 pending, 3 unused |
| reg_we_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt request to the host |

## Verification
The bench pulses every source on its own, which catches a swapped or shifted bit in the event packing. It then drives an event and a clear into the same bit in one cycle. A design that let the clear win would lose that event, and its status read would come back missing bit 16.

Partial clears and unmasking a bit that is already set are also covered. A design that cleared the whole word, or that only raised the interrupt on new events, would show a wrong status value or a low interrupt. Writes to the pending and unused offsets, and mask writes with the upper data bits set, expose designs that decode the address loosely or keep too many mask bits.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int XFER_W = 6;  // done / descriptor-full classes
  localparam int TAIL_W = 5;  // cpu qfull, global qfull, rx err, tx err, link
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STAT = 2'd0,
    REG_MASK = 2'd1,
    REG_PEND = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  function automatic int src_width(input int nports);
    return XFER_W + nports + TAIL_W;
  endfunction
endpackage

// File: rtl/isu_event_pack.sv
module isu_event_pack #(
  parameter int NP = 6,
  parameter int W  = isu_pkg::src_width(NP)
) (
  input  logic [isu_pkg::XFER_W-1:0] xfer_i,
  input  logic [NP-1:0]              qfull_i,
  input  logic                       cpu_qfull_i,
  input  logic                       glb_qfull_i,
  input  logic                       rx_err_i,
  input  logic                       tx_err_i,
  input  logic                       link_i,
  output logic [W-1:0]               ev_o
);
  // Layout, LSB first: transfer classes, per-port queue full, tail sources.
  assign ev_o = {link_i, tx_err_i, rx_err_i, glb_qfull_i, cpu_qfull_i,
                 qfull_i, xfer_i};
endmodule

// File: rtl/isu_sticky_status.sv
module isu_sticky_status #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ev_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] stat_next_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] stat_d;

  // A new event is ORed in after the clear, so it wins over a same-cycle clear.
  always_comb begin
    stat_d = stat_q;
    if (clr_en_i) stat_d = stat_d & ~clr_bits_i;
    stat_d = stat_d | ev_i;
  end

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= stat_d;
  end

  assign stat_o      = stat_q;
  assign stat_next_o = stat_d;
endmodule

// File: rtl/isu_mask_reg.sv
module isu_mask_reg #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [W-1:0] wbits_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] mask_next_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  assign mask_d = we_i ? wbits_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= '1;
    else     mask_q <= mask_d;
  end

  assign mask_o      = mask_q;
  assign mask_next_o = mask_d;
endmodule

// File: rtl/isu_readback.sv
module isu_readback #(
  parameter int W  = 17,
  parameter int DW = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [isu_pkg::ADDR_W-1:0] addr_i,
  input  logic [W-1:0]               stat_i,
  input  logic [W-1:0]               mask_i,
  output logic [DW-1:0]              rdata_o
);
  import isu_pkg::*;

  logic [W-1:0]  view;
  logic [DW-1:0] rdata_q;

  always_comb begin
    case (reg_sel_e'(addr_i))
      REG_STAT: view = stat_i;
      REG_MASK: view = mask_i;
      REG_PEND: view = stat_i & ~mask_i;
      default:  view = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= DW'(view);
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int NUM_PORTS = 6,
  parameter int DATA_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [isu_pkg::XFER_W-1:0] ev_xfer_i,
  input  logic [NUM_PORTS-1:0]       ev_qfull_i,
  input  logic                       ev_cpu_qfull_i,
  input  logic                       ev_glb_qfull_i,
  input  logic                       ev_rx_err_i,
  input  logic                       ev_tx_err_i,
  input  logic                       ev_link_i,
  input  logic [isu_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic                       reg_we_i,
  input  logic [DATA_W-1:0]          reg_wdata_i,
  output logic [DATA_W-1:0]          reg_rdata_o,
  output logic                       irq_o
);
  import isu_pkg::*;

  localparam int SRC_W = src_width(NUM_PORTS);

  logic [SRC_W-1:0] ev_vec;
  logic [SRC_W-1:0] stat_q, stat_d;
  logic [SRC_W-1:0] mask_q, mask_d;
  logic [SRC_W-1:0] wbits;
  logic             stat_wr, mask_wr;
  logic             irq_q;

  assign wbits   = reg_wdata_i[SRC_W-1:0];
  assign stat_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == REG_STAT);
  assign mask_wr = reg_we_i && (reg_sel_e'(reg_addr_i) == REG_MASK);

  isu_event_pack #(.NP(NUM_PORTS), .W(SRC_W)) u_pack (
    .xfer_i      (ev_xfer_i),
    .qfull_i     (ev_qfull_i),
    .cpu_qfull_i (ev_cpu_qfull_i),
    .glb_qfull_i (ev_glb_qfull_i),
    .rx_err_i    (ev_rx_err_i),
    .tx_err_i    (ev_tx_err_i),
    .link_i      (ev_link_i),
    .ev_o        (ev_vec)
  );

  isu_sticky_status #(.W(SRC_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .ev_i        (ev_vec),
    .clr_en_i    (stat_wr),
    .clr_bits_i  (wbits),
    .stat_o      (stat_q),
    .stat_next_o (stat_d)
  );

  isu_mask_reg #(.W(SRC_W)) u_mask (
    .clk         (clk),
    .rst         (rst),
    .we_i        (mask_wr),
    .wbits_i     (wbits),
    .mask_o      (mask_q),
    .mask_next_o (mask_d)
  );

  isu_readback #(.W(SRC_W), .DW(DATA_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (reg_addr_i),
    .stat_i  (stat_q),
    .mask_i  (mask_q),
    .rdata_o (reg_rdata_o)
  );

  // Registered from next-state values, so the line moves with the registers.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(stat_d & ~mask_d);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int W  = 17,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  ev,
  input logic          stat_wr,
  input logic          mask_wr,
  input logic [W-1:0]  wbits,
  input logic [W-1:0]  stat,
  input logic [W-1:0]  mask,
  input logic          irq,
  input logic [DW-1:0] rdata
);
  a_r1_reset_values: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (stat == '0 && mask == '1 && !irq));

  for (genvar i = 0; i < W; i++) begin : g_bit
    a_r2_event_sets: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> stat[i]);
    a_r3_clear_bit: assert property (@(posedge clk) disable iff (rst)
      (stat_wr && wbits[i] && !ev[i]) |=> !stat[i]);
    a_r3_hold_bit: assert property (@(posedge clk) disable iff (rst)
      (!ev[i] && !(stat_wr && wbits[i])) |=> $stable(stat[i]));
    a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
      (ev[i] && stat_wr && wbits[i]) |=> stat[i]);
  end

  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    mask_wr |=> (mask == $past(wbits)));
  a_r5_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !mask_wr |=> $stable(mask));
  a_r7_irq_level: assert property (@(posedge clk) disable iff (rst)
    irq == (|(stat & ~mask)));

  if (DW > W) begin : g_hi
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (rst)
      rdata[DW-1:W] == '0);
  end
endmodule

bind irq_status_unit irq_status_unit_chk #(.W(SRC_W), .DW(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ev      (ev_vec),
  .stat_wr (stat_wr),
  .mask_wr (mask_wr),
  .wbits   (wbits),
  .stat    (stat_q),
  .mask    (mask_q),
  .irq     (irq_o),
  .rdata   (reg_rdata_o)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;
  localparam int NP = 6;
  localparam int DW = 32;
  localparam int W  = 17;
  localparam logic [DW-1:0] ALL = 32'h0001_FFFF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  ev = '0;
  logic [1:0]    reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          irq;

  int n_chk  = 0;
  int n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  irq_status_unit #(.NUM_PORTS(NP), .DATA_W(DW)) u0 (
    .clk            (clk),
    .rst            (rst),
    .ev_xfer_i      (ev[5:0]),
    .ev_qfull_i     (ev[11:6]),
    .ev_cpu_qfull_i (ev[12]),
    .ev_glb_qfull_i (ev[13]),
    .ev_rx_err_i    (ev[14]),
    .ev_tx_err_i    (ev[15]),
    .ev_link_i      (ev[16]),
    .reg_addr_i     (reg_addr),
    .reg_we_i       (reg_we),
    .reg_wdata_i    (reg_wdata),
    .reg_rdata_o    (reg_rdata),
    .irq_o          (irq)
  );

  task automatic check(input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    check(tag, DW'(irq), DW'(exp));
  endtask

  task automatic pulse(input logic [W-1:0] bits);
    ev = bits;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Driver side of the scoreboard: push the expected read result.
  task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp,
                    input string tag);
    reg_addr = a; reg_we = 1'b0;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor side: R9, data is registered one edge after the address.
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      logic [DW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, reg_rdata, e);
    end
  end

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_irq(1'b0, "R1 irq after reset");
    rd(2'd0, 32'h0, "R1 status after reset");
    rd(2'd1, ALL, "R1 mask after reset");
    rd(2'd3, 32'h0, "R8 unused offset");

    // R2 walk through every source, each masked (R6)
    for (int i = 0; i < W; i++) begin
      pulse(W'(1) << i);
      chk_irq(1'b0, "R6 masked source keeps irq low");
      rd(2'd0, DW'(1) << i, "R2 single source bit position");
      wr(2'd0, DW'(1) << i);
    end
    rd(2'd0, 32'h0, "R3 walk cleared");

    pulse(17'h00001);
    wr(2'd1, 32'h0001_FFFE);
    chk_irq(1'b1, "R6 unmask set bit raises irq");
    rd(2'd2, 32'h1, "R8 pending view");
    repeat (5) @(negedge clk);
    chk_irq(1'b1, "R7 level holds");

    pulse(17'h18200);
    rd(2'd0, 32'h0001_8201, "R2 several sources");
    rd(2'd2, 32'h1, "R8 pending hides masked bits");

    wr(2'd0, 32'h0000_0200);
    rd(2'd0, 32'h0001_8001, "R3 clears only written bits");

    // R4: event and clear on bit 16 in the same cycle
    ev = 17'h10000;
    reg_addr = 2'd0; reg_we = 1'b1; reg_wdata = 32'h0001_0000;
    @(negedge clk);
    ev = '0; reg_we = 1'b0;
    rd(2'd0, 32'h0001_8001, "R4 event wins over clear");

    wr(2'd0, 32'h1);
    chk_irq(1'b0, "R7 irq falls after clear");
    rd(2'd0, 32'h0001_8000, "R3 partial clear");

    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd1, 32'h0001_FFFE, "R8 write to offset 2/3 leaves mask");
    rd(2'd0, 32'h0001_8000, "R8 write to offset 2/3 leaves status");
    rd(2'd3, 32'h0, "R8 offset 3 reads zero");

    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, ALL, "R5 upper mask bits dropped");
    chk_irq(1'b0, "R5 full mask silences irq");
    wr(2'd1, 32'h0000_7FFF);
    chk_irq(1'b1, "R5 cleared mask bit enables source");
    rd(2'd2, 32'h0001_8000, "R8 pending after unmask");

    wr(2'd0, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R7 irq low after full clear");
    rd(2'd0, 32'h0, "R3 clear all");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule